// File: doc/BRIEF.md
# Second-Order Delta-Sigma Bitstream Modulator

This block turns a stream of signed 16-bit samples into a one-bit stream whose long-run fraction of ones follows the input level. Two accumulating stages sit ahead of a sign decision. The decided bit is fed back as a fixed positive or negative level into both stages. The block stands in for the digital side of an isolated current-sense converter. Decimation filters, such as a third-order sinc filter decimating by 256, can therefore be verified against a known, repeatable bitstream without analog hardware.

The input level maps to a ones fraction of 0.5 + x/65536. Zero input gives half ones. An input of +20480 (62.5 % of full scale) gives 81.25 % ones and -20480 gives 18.75 %. A sinc3/256 filter truncated to 16 bits therefore reads 32768, 53248 and 12288 for these inputs. One bit is produced on each rising clock edge at which the clock enable is high. The bit is held in a register until the next such edge, so a consumer samples it on the following edge.

Top module: `sd2_modulator`

## Requirements
- R1: While synchronous reset is high, both accumulators clear and `bit_out` is 0. With input 0 and enable held high after release, the first four bits are 1, 0, 0, 1.
- R2: Let f = +32768 when a decision is 1 and -32768 when it is 0. Each enabled edge uses the values held before the edge. The decision is 1 exactly when the second accumulator is non-negative. The first accumulator adds floor((x - f)/2). The second accumulator adds floor((a1 - f)/2), where a1 is the first accumulator's old value.
- R3: `bit_out` is registered. After an enabled edge it equals the decision formed from the state held before that edge, and it changes at no other time.
- R4: While enable is low and reset is low, `bit_out` and both accumulators hold. When enabling resumes, the bit sequence continues as if no gap had occurred.
- R5: A zero input gives 8192 ones in 16384 enabled cycles, within ±33.
- R6: Inputs +20480 and -20480 give 81.25 % and 18.75 % ones, that is 13312 and 3072 ones in 16384 cycles, within ±33. These counts scale to 53248 and 12288 per 65536.
- R7: For any constant input x with |x| ≤ 24576, the count of ones over 16384 enabled cycles is 16384·(0.5 + x/65536), within ±0.2 %.
- R8: Full-scale input +32767 gives at least 99 % ones and -32768 gives at most 1 % ones.
- R9: Both accumulators saturate at ±(2^(ACC_W-1) - 1) and never wrap. After a full-scale run the loop recovers, and a following zero input again gives 50 % ± 0.2 % ones.
- R10: Reset takes effect even when enable is low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on rising edges |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; one output bit per enabled edge |
| sample_in | input | SAMPLE_W (16) | Signed two's-complement input sample |
| bit_out | output | 1 | Registered one-bit modulator output |

## Verification
Reset and a low clock enable can fall in the same cycle, and the design must let reset win. The bench brings the output to 1 and then raises reset while enable is held low. The output must read 0 at the next sample. After reset is released with enable high, the first bits must match a fresh post-reset sequence (1 then 0). That sequence proves the accumulators were cleared even though the enable never rose. Enable gaps inserted in the middle of that known sequence show that held cycles neither advance nor disturb the loop.

// File: rtl/sd2_pkg.sv
`timescale 1ns/1ps
package sd2_pkg;

  typedef enum logic {
    SD_LOW  = 1'b0,
    SD_HIGH = 1'b1
  } sd_level_e;

  // Symmetric clamp to +/-(2^(w-1)-1), applied to a wide signed sum.
  function automatic logic signed [63:0] sd_clamp(
    input logic signed [63:0] v,
    input int unsigned        w
  );
    logic signed [63:0] lim;
    lim = (64'sd1 <<< (w - 1)) - 64'sd1;
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/sd2_integrator.sv
`timescale 1ns/1ps
module sd2_integrator
  import sd2_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic signed [ACC_W-1:0] drive_i,
  input  logic signed [ACC_W-1:0] fb_i,
  output logic signed [ACC_W:0]   step_o,
  output logic signed [ACC_W-1:0] acc_o
);

  localparam int EXT = 64 - ACC_W;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [63:0]      wide_acc;
  logic signed [63:0]      wide_step;

  // Half of the difference, floor rounding via arithmetic shift.
  assign step_o = ($signed({drive_i[ACC_W-1], drive_i})
                 - $signed({fb_i[ACC_W-1], fb_i})) >>> 1;

  assign wide_acc  = $signed({{EXT{acc_q[ACC_W-1]}}, acc_q});
  assign wide_step = $signed({{(EXT-1){step_o[ACC_W]}}, step_o});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (ce) begin
      acc_q <= ACC_W'(sd_clamp(wide_acc + wide_step, ACC_W));
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/sd2_quantizer.sv
`timescale 1ns/1ps
module sd2_quantizer
  import sd2_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 24
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic                    decide_o,
  output logic signed [ACC_W-1:0] fb_o
);

  localparam int PAD = ACC_W - SAMPLE_W;
  localparam logic signed [ACC_W-1:0] FB_POS =
    {{PAD{1'b0}}, 1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] FB_NEG = -FB_POS;

  sd_level_e lvl;

  assign lvl      = (acc_i >= 0) ? SD_HIGH : SD_LOW;
  assign decide_o = (lvl == SD_HIGH);
  assign fb_o     = (lvl == SD_HIGH) ? FB_POS : FB_NEG;

endmodule

// File: rtl/sd2_modulator.sv
`timescale 1ns/1ps
module sd2_modulator #(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic                       bit_out
);

  localparam int STAGES = 2;
  localparam int EXT    = ACC_W - SAMPLE_W;

  logic signed [ACC_W-1:0] stage_in   [STAGES];
  logic signed [ACC_W-1:0] stage_acc  [STAGES];
  logic signed [ACC_W:0]   stage_step [STAGES];
  logic signed [ACC_W-1:0] fb_w;
  logic                    decide_w;

  assign stage_in[0] = {{EXT{sample_in[SAMPLE_W-1]}}, sample_in};

  // Cascade: each later stage integrates the previous stage's state.
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k > 0) begin : g_chain
        assign stage_in[k] = stage_acc[k-1];
      end
      sd2_integrator #(.ACC_W(ACC_W)) u_int (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .drive_i (stage_in[k]),
        .fb_i    (fb_w),
        .step_o  (stage_step[k]),
        .acc_o   (stage_acc[k])
      );
    end
  endgenerate

  sd2_quantizer #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_quant (
    .acc_i    (stage_acc[STAGES-1]),
    .decide_o (decide_w),
    .fb_o     (fb_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out <= 1'b0;
    end else if (ce) begin
      bit_out <= decide_w;
    end
  end

  // Named internal events for the checker.
  logic signed [ACC_W-1:0] acc1_w, acc2_w;
  logic signed [ACC_W:0]   step1_w, step2_w;
  assign acc1_w  = stage_acc[0];
  assign acc2_w  = stage_acc[1];
  assign step1_w = stage_step[0];
  assign step2_w = stage_step[1];

endmodule

// File: rtl/sd2_checker.sv
`timescale 1ns/1ps
module sd2_checker #(
  parameter int ACC_W = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ce,
  input logic                    bit_out,
  input logic signed [ACC_W-1:0] acc1,
  input logic signed [ACC_W-1:0] acc2,
  input logic signed [ACC_W:0]   step1,
  input logic signed [ACC_W:0]   step2
);

  // R1 and R10: reset clears state whatever the enable does
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (bit_out == 1'b0 && acc1 == 0 && acc2 == 0));

  // R4: disabled cycles hold everything
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(bit_out) && $stable(acc1) && $stable(acc2)));

  // R3: registered bit is the sign decision of the prior state
  a_r3_registered_sign: assert property (@(posedge clk) disable iff (rst)
    ce |=> (bit_out == ($past(acc2) >= 0)));

  // R9: saturation, never wrap
  a_r9_no_wrap_up1: assert property (@(posedge clk) disable iff (rst)
    (ce && acc1 >= 0 && step1 >= 0) |=> (acc1 >= 0));

  a_r9_no_wrap_up2: assert property (@(posedge clk) disable iff (rst)
    (ce && acc2 >= 0 && step2 >= 0) |=> (acc2 >= 0));

  a_r9_no_wrap_dn2: assert property (@(posedge clk) disable iff (rst)
    (ce && acc2 < 0 && step2 < 0) |=> (acc2 < 0));

endmodule

bind sd2_modulator sd2_checker #(.ACC_W(ACC_W)) u_sd2_checker (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .bit_out (bit_out),
  .acc1    (acc1_w),
  .acc2    (acc2_w),
  .step1   (step1_w),
  .step2   (step2_w)
);

// File: tb/sd2_modulator_bench.sv
`timescale 1ns/1ps
module sd2_modulator_bench;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               ce  = 1'b0;
  logic signed [15:0] sample_in = '0;
  logic               bit_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sd2_modulator u_sd2_modulator (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .sample_in (sample_in),
    .bit_out   (bit_out)
  );

  // Density table: input level and expected ones per 16384 cycles,
  // computed as 8192 + x/4. Entry 0 is R5, 1-2 are R6, the rest R7.
  localparam int VEC_N   = 7;
  localparam int WIN     = 16384;
  localparam int TOL     = 33;
  localparam int VEC_X [VEC_N] = '{0, 20480, -20480, 24576, -24576, 8000, -12344};
  localparam int VEC_E [VEC_N] = '{8192, 13312, 3072, 14336, 2048, 10192, 5106};

  task automatic check(input string tag, input int act, input int exp, input int tol);
    n_run++;
    if (act - exp > tol || exp - act > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
    end
  endtask

  task automatic measure(input int x, input int settle, output int ones);
    @(negedge clk);
    sample_in = 16'(x);
    ce = 1'b1;
    repeat (settle) @(negedge clk);
    ones = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      ones += int'(bit_out);
    end
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst = 1'b1;
    ce  = 1'b1;
    sample_in = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int ones;
    // R1: reset state and first bits
    enter_reset();
    check("R1 reset output", int'(bit_out), 0, 0);
    @(negedge clk); check("R1 bit1", int'(bit_out), 1, 0);
    @(negedge clk); check("R2 bit2", int'(bit_out), 0, 0);
    @(negedge clk); check("R2 bit3", int'(bit_out), 0, 0);
    @(negedge clk); check("R3 bit4", int'(bit_out), 1, 0);

    // R4: gaps inside the same sequence
    enter_reset();
    @(negedge clk); check("R4 first", int'(bit_out), 1, 0);
    ce = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); check("R4 hold high", int'(bit_out), 1, 0);
    end
    ce = 1'b1;
    @(negedge clk); check("R4 resume bit2", int'(bit_out), 0, 0);
    ce = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check("R4 hold low", int'(bit_out), 0, 0);
    end
    ce = 1'b1;
    @(negedge clk); check("R4 resume bit3", int'(bit_out), 0, 0);
    @(negedge clk); check("R4 resume bit4", int'(bit_out), 1, 0);

    // R10: reset with enable low while output is 1
    ce  = 1'b0;
    rst = 1'b1;
    @(negedge clk); check("R10 reset wins over ce low", int'(bit_out), 0, 0);
    rst = 1'b0;
    ce  = 1'b1;
    @(negedge clk); check("R10 fresh bit1", int'(bit_out), 1, 0);
    @(negedge clk); check("R10 fresh bit2", int'(bit_out), 0, 0);

    // R5, R6, R7: density table
    for (int v = 0; v < VEC_N; v++) begin
      measure(VEC_X[v], 64, ones);
      check($sformatf("R5/R6/R7 density x=%0d", VEC_X[v]), ones, VEC_E[v], TOL);
    end

    // R8: full scale both ways
    measure(32767, 64, ones);
    check("R8 positive full scale", ones, WIN, WIN / 100);
    measure(-32768, 64, ones);
    check("R8 negative full scale", ones, 0, WIN / 100);

    // R9: recovery after saturating run
    measure(0, 256, ones);
    check("R9 recovery to half density", ones, 8192, TOL);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule